// File: doc/BRIEF.md
# Fuse Array Byte-Window Read Sequencer

This block reads a window of bytes out of a one-time-programmable fuse macro that holds 32 words of 32 bits each. A request gives a byte offset and a byte count. The sequencer puts the macro in read mode and waits for the setup interval. It then strobes every word that overlaps the window, in ascending order. Each captured word is sliced into bytes, and only the bytes inside the window go out on a byte stream. When the last word has been read, the macro goes back to standby and a one-cycle done pulse is raised.

All timing is counted in clock cycles. The parameter `CYC_PER_US` gives the number of cycles in one microsecond, so every 1 µs interval the macro needs is met at any clock rate. The output stream is valid/ready. A byte is transferred in a cycle where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the byte stays on `m_data` and the sequencer waits, with the strobe held low. Back-pressure therefore stretches the time between strobes but never drops or repeats a byte. `i_start`, `i_offset`, `i_size`, `o_busy` and `o_done` are plain control pins.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset, and at all times while idle, `fuse_ctrl` equals the standby word 0x0000_0021. This word has power-down (bit 5) and chip-select-bar (bit 0) set and every other bit clear. `o_busy`, `m_valid` and `o_done` are low.
- R2: Read mode drives load (bit 2), program-enable-bar (bit 3), sense-bar (bit 7) and strobe-shift-select (bit 9) high and bits 0 and 5 low. No other bit is set outside the address field and the strobe. The first strobe rises only after read mode has held for at least `CYC_PER_US` cycles.
- R3: The strobe (bit 1) stays high for at least `CYC_PER_US` cycles. While it is high, the word address sits stable in bits 25:16. The data captured for that word is the macro output at the end of the high interval.
- R4: The strobe stays low for at least `CYC_PER_US` cycles before each following strobe, and again before the macro returns to standby.
- R5: The words strobed are start..end-1 in ascending order. Start is offset/4. End is ceil((offset+size)/4), clamped to 32.
- R6: The stream carries bytes offset..min(offset+size,128)-1 in ascending order. Byte k of a word is its bits 8k+7:8k (byte 0 least significant).
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` is unchanged in the next cycle. No byte is lost or repeated under any ready pattern.
- R8: A request with size 0 or offset of 128 or more produces no strobe and no byte. `o_done` is high in the cycle after the start cycle, and `fuse_ctrl` stays at standby.
- R9: After the last word, `o_done` pulses for exactly one cycle, `o_busy` falls, and `fuse_ctrl` is back at the standby word.
- R10: `i_start` is ignored while `o_busy` is high. The running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | One-cycle request pulse, taken while idle |
| i_offset | input | 8 | First byte of the window |
| i_size | input | 8 | Number of bytes requested |
| o_busy | output | 1 | High while a request is in progress |
| o_done | output | 1 | One-cycle pulse at the end of a request |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream byte accepted by the sink |
| m_data | output | 8 | Stream byte |
| fuse_ctrl | output | 32 | Control word to the fuse macro: pin bits and word address field |
| fuse_dout | input | 32 | Data word from the fuse macro |

## Verification
Bytes are due on any cycle in which valid and ready meet, so the bench collects them at every falling edge where both are high and compares the whole sequence after done. It also checks the count. The empty-request done pulse is due one cycle after the start edge and is sampled at the very next falling edge. The standby word is checked one falling edge after done. Strobe spacing and width are measured in cycles at every falling edge against `CYC_PER_US`. The bench fuse model returns a poison word unless the strobe has been high for the full interval, so a capture made too early shows up as wrong data.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int CTRL_W   = 32;
  localparam int CB_CSB   = 0;
  localparam int CB_STB   = 1;
  localparam int CB_LOAD  = 2;
  localparam int CB_PGENB = 3;
  localparam int CB_PD    = 5;
  localparam int CB_RSB   = 7;
  localparam int CB_SSS   = 9;
  localparam int ADDR_LSB = 16;
  localparam int ADDR_W   = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_EMIT, ST_HOLD
  } seq_state_t;

  function automatic logic [CTRL_W-1:0] standby_word();
    logic [CTRL_W-1:0] w;
    w = '0;
    w[CB_PD]  = 1'b1;
    w[CB_CSB] = 1'b1;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] readmode_word();
    logic [CTRL_W-1:0] w;
    w = '0;
    w[CB_LOAD]  = 1'b1;
    w[CB_PGENB] = 1'b1;
    w[CB_RSB]   = 1'b1;
    w[CB_SSS]   = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/fuse_dly_cnt.sv
module fuse_dly_cnt #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);
endmodule

// File: rtl/fuse_win_calc.sv
module fuse_win_calc #(
  parameter int OFF_W  = 8,
  parameter int SIZE_W = 8,
  parameter int NWORDS = 32,
  parameter int BPW    = 4
) (
  input  logic [OFF_W-1:0]                     offset,
  input  logic [SIZE_W-1:0]                    size,
  output logic                                 empty,
  output logic [$clog2(NWORDS+1)-1:0]          start_word,
  output logic [$clog2(NWORDS+1)-1:0]          end_word,
  output logic [$clog2(NWORDS*BPW+1)-1:0]      first_byte,
  output logic [$clog2(NWORDS*BPW+1)-1:0]      end_byte
);
  localparam int NBYTES = NWORDS * BPW;
  localparam int LANE_W = $clog2(BPW);
  localparam int WORD_W = $clog2(NWORDS + 1);
  localparam int BYTE_W = $clog2(NBYTES + 1);
  localparam int SUM_W  = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 2;

  localparam logic [SUM_W-1:0] NBYTES_S = SUM_W'(NBYTES);
  localparam logic [SUM_W-1:0] NWORDS_S = SUM_W'(NWORDS);
  localparam logic [SUM_W-1:0] ROUND_S  = SUM_W'(BPW - 1);

  logic [SUM_W-1:0] off_s, sum_s, ceil_s, endb_s;

  always_comb begin
    off_s  = SUM_W'(offset);
    sum_s  = off_s + SUM_W'(size);
    ceil_s = (sum_s + ROUND_S) >> LANE_W;
    endb_s = (sum_s > NBYTES_S) ? NBYTES_S : sum_s;
    empty      = (size == '0) || (off_s >= NBYTES_S);
    start_word = WORD_W'(off_s >> LANE_W);
    end_word   = WORD_W'((ceil_s > NWORDS_S) ? NWORDS_S : ceil_s);
    first_byte = BYTE_W'(off_s);
    end_byte   = BYTE_W'(endb_s);
  end
endmodule

// File: rtl/fuse_lane_mux.sv
module fuse_lane_mux #(
  parameter int BPW = 4
) (
  input  logic [BPW*8-1:0]                      word,
  input  logic [(BPW > 1 ? $clog2(BPW) : 1)-1:0] lane,
  output logic [7:0]                            byte_out
);
  logic [BPW-1:0][7:0] lanes;

  for (genvar k = 0; k < BPW; k++) begin : g_lane
    assign lanes[k] = word[k*8 +: 8];
  end

  assign byte_out = lanes[lane];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int NWORDS     = 32,
  parameter int BPW        = 4,
  parameter int OFF_W      = 8,
  parameter int SIZE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_start,
  input  logic [OFF_W-1:0]  i_offset,
  input  logic [SIZE_W-1:0] i_size,
  output logic              o_busy,
  output logic              o_done,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic [31:0]       fuse_ctrl,
  input  logic [31:0]       fuse_dout
);
  localparam int NBYTES = NWORDS * BPW;
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int WORD_W = $clog2(NWORDS + 1);
  localparam int BYTE_W = $clog2(NBYTES + 1);
  localparam int DATA_W = BPW * 8;

  seq_state_t         state;
  logic [WORD_W-1:0]  word, end_word;
  logic [BYTE_W-1:0]  cur_byte, end_byte;
  logic [DATA_W-1:0]  data_q;

  logic               req_empty;
  logic [WORD_W-1:0]  req_start_word, req_end_word;
  logic [BYTE_W-1:0]  req_first_byte, req_end_byte;
  logic               tmr_clr, tmr_exp;
  logic               emitting, more_words, accept;
  logic [WORD_W-1:0]  word_nxt;

  fuse_win_calc #(
    .OFF_W(OFF_W), .SIZE_W(SIZE_W), .NWORDS(NWORDS), .BPW(BPW)
  ) u_win (
    .offset     (i_offset),
    .size       (i_size),
    .empty      (req_empty),
    .start_word (req_start_word),
    .end_word   (req_end_word),
    .first_byte (req_first_byte),
    .end_byte   (req_end_byte)
  );

  fuse_dly_cnt #(.LIMIT(CYC_PER_US)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .expired (tmr_exp)
  );

  fuse_lane_mux #(.BPW(BPW)) u_lane (
    .word     (data_q[DATA_W-1:0]),
    .lane     (LANE_W'(cur_byte)),
    .byte_out (m_data)
  );

  assign accept     = (state == ST_IDLE) && i_start;
  assign word_nxt   = word + 1'b1;
  assign more_words = (word_nxt < end_word);
  assign emitting   = (cur_byte < end_byte) &&
                      (WORD_W'(cur_byte >> LANE_W) == word);

  always_comb begin
    tmr_clr = 1'b0;
    unique case (state)
      ST_IDLE:   tmr_clr = accept && !req_empty;
      ST_SETUP:  tmr_clr = tmr_exp;
      ST_STROBE: tmr_clr = 1'b0;
      ST_EMIT:   tmr_clr = !emitting;
      ST_HOLD:   tmr_clr = tmr_exp && more_words;
      default:   tmr_clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word     <= '0;
      end_word <= '0;
      cur_byte <= '0;
      end_byte <= '0;
      data_q   <= '0;
      o_done   <= 1'b0;
    end else begin
      o_done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (req_empty) begin
            o_done <= 1'b1;
          end else begin
            state    <= ST_SETUP;
            word     <= req_start_word;
            end_word <= req_end_word;
            cur_byte <= req_first_byte;
            end_byte <= req_end_byte;
          end
        end
        ST_SETUP: if (tmr_exp) state <= ST_STROBE;
        ST_STROBE: if (tmr_exp) begin
          data_q <= fuse_dout[DATA_W-1:0];
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          if (!emitting)    state    <= ST_HOLD;
          else if (m_ready) cur_byte <= cur_byte + 1'b1;
        end
        ST_HOLD: if (tmr_exp) begin
          if (more_words) begin
            word  <= word_nxt;
            state <= ST_STROBE;
          end else begin
            state  <= ST_IDLE;
            o_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign o_busy  = (state != ST_IDLE);
  assign m_valid = (state == ST_EMIT) && emitting;

  always_comb begin
    if (state == ST_IDLE) begin
      fuse_ctrl = standby_word();
    end else begin
      fuse_ctrl = readmode_word();
      fuse_ctrl[ADDR_LSB +: ADDR_W] = ADDR_W'(word);
      fuse_ctrl[CB_STB] = (state == ST_STROBE);
    end
  end
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk
  import fuse_rd_pkg::*;
#(
  parameter int NWORDS = 32,
  parameter int SIZE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_start,
  input logic [SIZE_W-1:0] i_size,
  input logic              o_busy,
  input logic              o_done,
  input logic              m_valid,
  input logic              m_ready,
  input logic [7:0]        m_data,
  input logic [31:0]       fuse_ctrl
);
  logic              stb;
  logic [ADDR_W-1:0] addr;
  assign stb  = fuse_ctrl[CB_STB];
  assign addr = fuse_ctrl[ADDR_LSB +: ADDR_W];

  assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !o_busy |-> (fuse_ctrl == 32'h0000_0021) && !m_valid);

  assert_strobe_readmode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> fuse_ctrl[CB_LOAD] && fuse_ctrl[CB_PGENB] && fuse_ctrl[CB_RSB] &&
            fuse_ctrl[CB_SSS] && !fuse_ctrl[CB_PD] && !fuse_ctrl[CB_CSB]);

  assert_strobe_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (addr < ADDR_W'(NWORDS)));

  assert_strobe_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb && $past(stb) |-> $stable(addr));

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_no_strobe_while_streaming_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !stb && o_busy);

  assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    i_start && !o_busy && (i_size == '0) |=> o_done && !o_busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |=> !o_done);
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.NWORDS(NWORDS), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_size(i_size),
  .o_busy(o_busy), .o_done(o_done), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .fuse_ctrl(fuse_ctrl)
);

// File: tb/sim_fuse_rd_seq.sv
module sim_fuse_rd_seq;
  localparam int LIM = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_start = 1'b0;
  logic [7:0]  i_offset = '0;
  logic [7:0]  i_size = '0;
  logic        o_busy, o_done, m_valid, m_data_dummy;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;
  logic [31:0] fuse_ctrl, fuse_dout;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;

  always #5 clk = ~clk;

  fuse_rd_seq #(.CYC_PER_US(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_offset(i_offset),
    .i_size(i_size), .o_busy(o_busy), .o_done(o_done), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout)
  );
  assign m_data_dummy = 1'b0;

  function automatic logic [31:0] fw(int w);
    logic [31:0] a;
    a = 32'(w);
    return (32'h9E37_79B9 * (a + 1)) ^ {a[7:0], a[7:0], 8'hC3, a[7:0]};
  endfunction

  function automatic logic [7:0] fbyte(int b);
    logic [31:0] v;
    v = fw(b / 4);
    return v[(b % 4) * 8 +: 8];
  endfunction

  // behavioural fuse macro: data valid only after a full strobe interval
  int sc = 0;
  always @(posedge clk) sc <= fuse_ctrl[1] ? sc + 1 : 0;
  assign fuse_dout = (fuse_ctrl[1] && sc >= LIM - 1) ?
                     fw(int'(fuse_ctrl[25:16])) : 32'hBAD0_BAD0;

  // ready driver, away from the sampling edge
  always @(posedge clk) begin
    #1;
    m_ready = (rdy_mode == 0) ? 1'b1 : 1'($urandom % 2);
  end

  // monitors
  logic [7:0] got [0:255];
  int got_n = 0, strb_addr [0:63], strb_n = 0;
  int lowcnt = 0, hicnt = 0;
  bit bad_mode = 0, bad_low = 0, bad_hi = 0, bad_hold = 0;
  logic p_st = 0, p_rm = 0, p_v = 0, p_r = 0;
  logic [7:0] p_d = '0;

  always @(negedge clk) if (rst_n) begin
    logic st, rm;
    st = fuse_ctrl[1];
    rm = fuse_ctrl[2];
    if (m_valid && m_ready) begin
      if (got_n < 256) got[got_n] = m_data;
      got_n++;
    end
    if (p_v && !p_r && (!m_valid || m_data != p_d)) bad_hold = 1;
    if (rm && ((fuse_ctrl & 32'hFC00_FFFD) != 32'h0000_028C)) bad_mode = 1;
    if (!rm && fuse_ctrl != 32'h0000_0021) bad_mode = 1;
    if (st) begin
      if (!p_st) begin
        if (lowcnt < LIM) bad_low = 1;
        if (strb_n < 64) strb_addr[strb_n] = int'(fuse_ctrl[25:16]);
        strb_n++;
        hicnt = 0;
      end
      hicnt++;
      lowcnt = 0;
    end else if (rm) begin
      if (p_st && hicnt < LIM) bad_hi = 1;
      lowcnt++;
    end else begin
      if (p_rm && lowcnt < LIM) bad_low = 1;
      lowcnt = 0;
    end
    p_st = st; p_rm = rm; p_v = m_valid; p_r = m_ready; p_d = m_data;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic go(int off, int sz, bit interfere);
    int endb, sw, ew, cyc, nexp, first_bad;
    bit empty, seen;
    got_n = 0; strb_n = 0;
    bad_mode = 0; bad_low = 0; bad_hi = 0; bad_hold = 0;
    empty = (sz == 0) || (off >= 128);
    endb  = (off + sz > 128) ? 128 : off + sz;
    sw    = off / 4;
    ew    = (off + sz + 3) / 4;
    if (ew > 32) ew = 32;
    @(posedge clk); #1;
    i_start = 1; i_offset = 8'(off); i_size = 8'(sz);
    @(posedge clk); #1;
    i_start = 0;
    if (empty) begin
      @(negedge clk);
      check(o_done === 1'b1, "R8", "done one cycle after empty start", int'(o_done), 1);
      repeat (3) @(negedge clk);
      check(strb_n == 0 && got_n == 0 && fuse_ctrl == 32'h21, "R8",
            "no strobe, no byte, standby", strb_n + got_n, 0);
      return;
    end
    seen = 0; cyc = 0;
    while (!seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (interfere && cyc == 5) begin
        i_start = 1; i_offset = 8'(60); i_size = 8'(3);
      end else if (interfere && cyc == 6) begin
        i_start = 0;
      end
      seen = o_done;
    end
    check(seen, "R9", "done pulse seen", int'(seen), 1);
    @(negedge clk);
    check(fuse_ctrl == 32'h21 && !o_busy && !o_done, "R9", "standby after done",
          int'(fuse_ctrl), 32'h21);
    nexp = endb - off;
    check(got_n == nexp, interfere ? "R10" : "R6", "byte count", got_n, nexp);
    first_bad = -1;
    for (int i = 0; i < nexp && i < got_n; i++)
      if (first_bad < 0 && got[i] != fbyte(off + i)) first_bad = i;
    if (first_bad >= 0)
      check(0, "R6", "byte value", int'(got[first_bad]), int'(fbyte(off + first_bad)));
    else
      check(1, "R6", "byte value", 0, 0);
    check(strb_n == ew - sw, "R5", "strobe count", strb_n, ew - sw);
    for (int i = 0; i < strb_n && i < 64; i++)
      if (strb_addr[i] != sw + i) begin
        check(0, "R5", "strobe address", strb_addr[i], sw + i);
        break;
      end
    check(!bad_mode, "R2", "control word shape", int'(bad_mode), 0);
    check(!bad_low, "R4", "strobe low spacing", int'(bad_low), 0);
    check(!bad_hi, "R3", "strobe high width", int'(bad_hi), 0);
    check(!bad_hold, "R7", "stalled byte held", int'(bad_hold), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    check(fuse_ctrl == 32'h21 && !o_busy && !m_valid && !o_done, "R1",
          "standby in reset", int'(fuse_ctrl), 32'h21);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(fuse_ctrl == 32'h21 && !o_busy && !m_valid && !o_done, "R1",
          "standby after reset", int'(fuse_ctrl), 32'h21);
    rdy_mode = 0;
    go(0, 128, 0);
    go(127, 1, 0);
    go(126, 200, 0);
    go(3, 2, 0);
    go(5, 4, 0);
    go(0, 0, 0);
    go(128, 10, 0);
    go(200, 255, 0);
    go(0, 20, 1);
    rdy_mode = 1;
    go(1, 30, 0);
    go(124, 4, 0);
    for (int t = 0; t < 40; t++) begin
      int o, s;
      rdy_mode = int'($urandom % 2);
      o = int'($urandom % 140);
      s = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 40);
      go(o, s, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule